// File: doc/BRIEF.md
# Operand-2 Barrel Shifter

This combinational block forms the second source operand of a 32-bit data-processing execute stage. It reads the low 12-bit operand field of the current instruction and an immediate-select bit. From these it either builds a constant or reshapes a register value. The register-file read addresses come straight from the operand field. The block returns the 32-bit operand together with a shifter carry-out, which the ALU uses as the new C flag for logical operations.

In constant form, an 8-bit literal is rotated right by an even amount. In register form, the value on the Rm read port is shifted left, shifted right with zero fill, shifted right with sign fill, or rotated right. The shift distance is either a 5-bit count held in the instruction or the low byte of the value on the Rs read port. Distances of 32 and above follow fixed saturation rules. A zero distance leaves both the value and the incoming carry untouched.

Top module: `op2_shifter`

## Requirements
- R1: When `imm_sel` is 1, `operand` equals the zero-extended literal `op_field[7:0]` rotated right by twice `op_field[11:8]`. `carry_out` equals `carry_in` if `op_field[11:8]` is 0, and `operand[31]` otherwise.
- R2: `rm_idx` always equals `op_field[3:0]` and `rs_idx` always equals `op_field[11:8]`.
- R3: In register form, `op_field[4]`=0 takes the distance from `op_field[11:7]`, and `op_field[4]`=1 takes it from `rs_val[7:0]`. Bits 31:8 of `rs_val` have no effect.
- R4: The kind of shift is coded in `op_field[6:5]`: 00 shift left with zero fill, 01 shift right with zero fill, 10 shift right with sign fill, 11 rotate right.
- R5: A distance of 0, of any kind, gives `operand` = `rm_val` and `carry_out` = `carry_in`.
- R6: For a distance n from 1 to 31, `carry_out` is the last bit moved out: `rm_val[32-n]` for a left shift, and `rm_val[n-1]` for the three right-going kinds.
- R7: A distance of exactly 32 gives `operand` = 0 for both zero-fill shifts, with `carry_out` = `rm_val[0]` for a left shift and `rm_val[31]` for a right shift.
- R8: A distance above 32 gives `operand` = 0 and `carry_out` = 0 for both zero-fill shifts.
- R9: A sign-fill shift by 32 or more fills `operand` with copies of `rm_val[31]` and gives `carry_out` = `rm_val[31]`.
- R10: A rotate by 32 or more acts as a rotate by the distance modulo 32. When that remainder is 0, `operand` = `rm_val` and `carry_out` = `rm_val[31]`.
- R11: When `imm_sel` is 1, `rm_val` and `rs_val` have no effect on `operand` or `carry_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_field | input | 12 | Low 12-bit operand field of the instruction |
| imm_sel | input | 1 | 1 selects the rotated-constant form |
| rm_val | input | 32 | Value read from the register addressed by `rm_idx` |
| rs_val | input | 32 | Value read from the register addressed by `rs_idx` |
| carry_in | input | 1 | Current C flag |
| rm_idx | output | 4 | Read address for the shifted register |
| rs_idx | output | 4 | Read address for the shift-distance register |
| operand | output | 32 | Second operand for the ALU |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The block holds no state, so a wrong decode or a wrong saturation choice shows on `operand` or `carry_out` within the same cycle as the stimulus. The most fragile points are the boundary distances 0, 31, 32 and 33, and distances that take their count from an Rs value whose upper bits are set. An unnoticed wrap of the 8-bit count, or a misread of the distance-source bit, gives a plausible-looking but wrong operand. For that reason the expected values come from a bit-at-a-time reference, checked against every kind of shift across those distances.

// File: rtl/op2_pkg.sv
package op2_pkg;

    localparam int WORD_W  = 32;
    localparam int FIELD_W = 12;
    localparam int AMT_W   = 8;
    localparam int IMM_W   = 8;
    localparam int ROT_W   = 4;
    localparam int IDX_W   = 4;

    // Bit positions inside the operand field that the decoder depends on
    localparam int POS_RM_LO   = 0;
    localparam int POS_SRC_SEL = 4;
    localparam int POS_KIND_LO = 5;
    localparam int POS_CNT_LO  = 7;
    localparam int POS_RS_LO   = 8;
    localparam int CNT_W       = 5;

    typedef enum logic [1:0] {
        SH_LEFT       = 2'b00,
        SH_RIGHT_ZERO = 2'b01,
        SH_RIGHT_SIGN = 2'b10,
        SH_ROTATE     = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic [AMT_W-1:0]  amount;
        shift_kind_e       kind;
    } shift_req_t;

    // Constant form rotates by an even distance: twice the 4-bit field
    function automatic logic [AMT_W-1:0] even_rotation(input logic [ROT_W-1:0] r);
        return AMT_W'({r, 1'b0});
    endfunction

endpackage

// File: rtl/op2_decode.sv
module op2_decode
    import op2_pkg::*;
(
    input  logic [FIELD_W-1:0] field,
    input  logic               imm_sel,
    input  logic [WORD_W-1:0]  rm_val,
    input  logic [WORD_W-1:0]  rs_val,
    output shift_req_t         req,
    output logic [IDX_W-1:0]   rm_idx,
    output logic [IDX_W-1:0]   rs_idx
);

    logic [CNT_W-1:0] field_cnt;
    logic [1:0]       field_kind;
    logic             cnt_from_reg;

    assign rm_idx       = field[POS_RM_LO +: IDX_W];
    assign rs_idx       = field[POS_RS_LO +: IDX_W];
    assign field_cnt    = field[POS_CNT_LO +: CNT_W];
    assign field_kind   = field[POS_KIND_LO +: 2];
    assign cnt_from_reg = field[POS_SRC_SEL];

    always_comb begin
        if (imm_sel) begin
            req.value  = WORD_W'(field[IMM_W-1:0]);
            req.amount = even_rotation(field[POS_RS_LO +: ROT_W]);
            req.kind   = SH_ROTATE;
        end else begin
            req.value  = rm_val;
            req.kind   = shift_kind_e'(field_kind);
            req.amount = cnt_from_reg ? rs_val[AMT_W-1:0] : AMT_W'(field_cnt);
        end
    end

    // R3: a count taken from the instruction never exceeds the 5-bit range
    always_comb begin
        if (!$isunknown({field, imm_sel})) begin
            a_r3_field_count_range: assert (imm_sel || cnt_from_reg || req.amount < AMT_W'(32));
        end
    end

endmodule

// File: rtl/op2_shift_core.sv
module op2_shift_core
    import op2_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DIST_W = 8
) (
    input  logic [DATA_W-1:0] value,
    input  logic [DIST_W-1:0] amount,
    input  shift_kind_e       kind,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              carry_out
);

    localparam int SH_W = $clog2(DATA_W);
    localparam logic [SH_W:0] FULL = (SH_W+1)'(DATA_W);

    logic [SH_W-1:0]  low;
    logic             is_zero;
    logic             is_exact;
    logic             is_over;
    logic [DATA_W:0]  lsl_w;
    logic [DATA_W:0]  lsr_w;
    logic [DATA_W:0]  asr_w;
    logic [DATA_W-1:0] ror_v;

    assign low      = amount[SH_W-1:0];
    assign is_zero  = (amount == '0);
    assign is_exact = (amount == DIST_W'(DATA_W));
    assign is_over  = (amount >  DIST_W'(DATA_W));

    // Widened by one bit so the last bit moved out lands in the extra slot
    assign lsl_w = {1'b0, value} << low;
    assign lsr_w = {value, 1'b0} >> low;
    assign asr_w = $unsigned($signed({value, 1'b0}) >>> low);
    assign ror_v = (value >> low) | (value << (FULL - {1'b0, low}));

    always_comb begin
        result    = value;
        carry_out = carry_in;
        if (!is_zero) begin
            unique case (kind)
                SH_LEFT: begin
                    if (is_exact) begin
                        result    = '0;
                        carry_out = value[0];
                    end else if (is_over) begin
                        result    = '0;
                        carry_out = 1'b0;
                    end else begin
                        result    = lsl_w[DATA_W-1:0];
                        carry_out = lsl_w[DATA_W];
                    end
                end
                SH_RIGHT_ZERO: begin
                    if (is_exact) begin
                        result    = '0;
                        carry_out = value[DATA_W-1];
                    end else if (is_over) begin
                        result    = '0;
                        carry_out = 1'b0;
                    end else begin
                        result    = lsr_w[DATA_W:1];
                        carry_out = lsr_w[0];
                    end
                end
                SH_RIGHT_SIGN: begin
                    if (is_exact || is_over) begin
                        result    = {DATA_W{value[DATA_W-1]}};
                        carry_out = value[DATA_W-1];
                    end else begin
                        result    = asr_w[DATA_W:1];
                        carry_out = asr_w[0];
                    end
                end
                default: begin
                    // rotate: distance taken modulo the word width
                    result    = ror_v;
                    carry_out = ror_v[DATA_W-1];
                end
            endcase
        end
    end

    always_comb begin
        if (!$isunknown({value, amount, kind, carry_in})) begin
            a_r5_zero_distance: assert (!is_zero || (result == value && carry_out == carry_in));
            a_r8_zero_fill_beyond: assert (!(is_over && (kind == SH_LEFT || kind == SH_RIGHT_ZERO))
                                           || (result == '0 && !carry_out));
            a_r9_sign_saturates: assert (!(kind == SH_RIGHT_SIGN && (is_exact || is_over))
                                         || (($countones(result) == 0 || $countones(result) == DATA_W)
                                             && carry_out == value[DATA_W-1]));
            a_r10_rotate_keeps_ones: assert (kind != SH_ROTATE
                                             || $countones(result) == $countones(value));
        end
    end

endmodule

// File: rtl/op2_shifter.sv
module op2_shifter
    import op2_pkg::*;
(
    input  logic [11:0] op_field,
    input  logic        imm_sel,
    input  logic [31:0] rm_val,
    input  logic [31:0] rs_val,
    input  logic        carry_in,
    output logic [3:0]  rm_idx,
    output logic [3:0]  rs_idx,
    output logic [31:0] operand,
    output logic        carry_out
);

    shift_req_t req;

    op2_decode u_decode (
        .field   (op_field),
        .imm_sel (imm_sel),
        .rm_val  (rm_val),
        .rs_val  (rs_val),
        .req     (req),
        .rm_idx  (rm_idx),
        .rs_idx  (rs_idx)
    );

    op2_shift_core #(
        .DATA_W (WORD_W),
        .DIST_W (AMT_W)
    ) u_core (
        .value     (req.value),
        .amount    (req.amount),
        .kind      (req.kind),
        .carry_in  (carry_in),
        .result    (operand),
        .carry_out (carry_out)
    );

    always_comb begin
        if (!$isunknown({op_field, imm_sel, carry_in})) begin
            a_r1_const_ones: assert (!imm_sel || $countones(operand) == $countones(op_field[7:0]));
            a_r1_const_carry: assert (!(imm_sel && op_field[11:8] != 4'd0) || carry_out == operand[31]);
        end
    end

endmodule

// File: tb/sim_op2_shifter.sv
module sim_op2_shifter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] fld = '0;
    logic        isel = 1'b0;
    logic [31:0] rm = '0;
    logic [31:0] rs = '0;
    logic        cin = 1'b0;
    logic [3:0]  rm_idx, rs_idx;
    logic [31:0] opnd;
    logic        cout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    op2_shifter u0 (
        .op_field  (fld),
        .imm_sel   (isel),
        .rm_val    (rm),
        .rs_val    (rs),
        .carry_in  (cin),
        .rm_idx    (rm_idx),
        .rs_idx    (rs_idx),
        .operand   (opnd),
        .carry_out (cout)
    );

    // Bit-at-a-time reference: kind 0 left, 1 right zero, 2 right sign, 3 rotate
    function automatic void ref_shift(input logic [31:0] v, input int n, input int k,
                                      input logic ci, output logic [31:0] r, output logic c);
        r = v;
        c = ci;
        for (int i = 0; i < n; i++) begin
            case (k)
                0: begin c = r[31]; r = {r[30:0], 1'b0}; end
                1: begin c = r[0];  r = {1'b0, r[31:1]}; end
                2: begin c = r[0];  r = {r[31], r[31:1]}; end
                default: begin c = r[0]; r = {r[0], r[31:1]}; end
            endcase
        end
    endfunction

    function automatic string tag_of(input int k, input int n);
        if (n == 0) return "R5";
        if (n < 32) return "R6";
        if (k == 2) return "R9";
        if (k == 3) return "R10";
        if (n == 32) return "R7";
        return "R8";
    endfunction

    task automatic apply(input logic [11:0] f, input logic s, input logic [31:0] a,
                         input logic [31:0] b, input logic c);
        @(posedge clk);
        fld = f; isel = s; rm = a; rs = b; cin = c;
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] exp_op, input logic exp_c);
        checks++;
        if (opnd !== exp_op || cout !== exp_c) begin
            errors++;
            $display("FAIL %s: operand=%h carry=%b expected operand=%h carry=%b",
                     tag, opnd, cout, exp_op, exp_c);
        end
    endtask

    task automatic t_reset;
        apply(12'h000, 1'b0, 32'h0, 32'h0, 1'b0);
        chk("R5 reset state", 32'h0, 1'b0);
    endtask

    task automatic t_const;
        int rots[4] = '{0, 1, 4, 15};
        logic [31:0] er;
        logic ec;
        for (int i = 0; i < 4; i++) begin
            for (int c = 0; c < 2; c++) begin
                ref_shift(32'h0000_00A5, 2 * rots[i], 3, c[0], er, ec);
                apply({rots[i][3:0], 8'hA5}, 1'b1, 32'hDEAD_BEEF, 32'h1, c[0]);
                chk("R1 constant rotate", er, ec);
            end
        end
    endtask

    task automatic t_const_ignore;
        logic [31:0] er;
        logic ec;
        ref_shift(32'h0000_0081, 6, 3, 1'b0, er, ec);
        apply(12'h381, 1'b1, 32'h0000_0000, 32'h0000_0000, 1'b0);
        chk("R11 constant vs register inputs", er, ec);
        apply(12'h381, 1'b1, 32'hFFFF_FFFF, 32'h0000_00FF, 1'b0);
        chk("R11 constant vs register inputs", er, ec);
        apply(12'h381, 1'b1, 32'h8000_0001, 32'h5555_5520, 1'b0);
        chk("R11 constant vs register inputs", er, ec);
    endtask

    task automatic t_addr;
        logic [11:0] pats[3] = '{12'hA5C, 12'h3F1, 12'hF0E};
        for (int i = 0; i < 3; i++) begin
            apply(pats[i], i[0], 32'h0, 32'h0, 1'b0);
            checks++;
            if (rm_idx !== pats[i][3:0] || rs_idx !== pats[i][11:8]) begin
                errors++;
                $display("FAIL R2: rm_idx=%h rs_idx=%h expected rm_idx=%h rs_idx=%h",
                         rm_idx, rs_idx, pats[i][3:0], pats[i][11:8]);
            end
        end
    endtask

    task automatic t_field_count;
        int amts[5] = '{0, 1, 7, 16, 31};
        logic [31:0] vals[2] = '{32'h8000_00F1, 32'h4F00_0A0C};
        logic [31:0] er;
        logic ec;
        for (int v = 0; v < 2; v++)
            for (int k = 0; k < 4; k++)
                for (int a = 0; a < 5; a++) begin
                    ref_shift(vals[v], amts[a], k, a[0], er, ec);
                    // Rs carries a different count; R3 says the field count wins
                    apply({amts[a][4:0], k[1:0], 1'b0, 4'h2}, 1'b0, vals[v], 32'h0000_0003, a[0]);
                    chk({"R3 R4 field count ", tag_of(k, amts[a])}, er, ec);
                end
    endtask

    task automatic t_reg_count;
        int amts[8] = '{0, 5, 31, 32, 33, 64, 200, 255};
        logic [31:0] vals[2] = '{32'h8765_4321, 32'h0F0F_00F3};
        logic [31:0] er;
        logic ec;
        for (int v = 0; v < 2; v++)
            for (int k = 0; k < 4; k++)
                for (int a = 0; a < 8; a++) begin
                    ref_shift(vals[v], amts[a], k, v[0], er, ec);
                    apply({4'h7, 1'b0, k[1:0], 1'b1, 4'h1}, 1'b0, vals[v],
                          32'h1234_5600 | 32'(amts[a]), v[0]);
                    chk({"R3 R4 register count ", tag_of(k, amts[a])}, er, ec);
                end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        t_reset();
        t_const();
        t_const_ignore();
        t_addr();
        t_field_count();
        t_reg_count();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule